// File: doc/BRIEF.md
# Smart Card Character Receiver

This block receives a single asynchronous character from the bidirectional, open-drain I/O line of a contact smart card. All timing is counted in cycles of the card clock `clk`: one elementary time unit (ETU) is `ETU_CYCLES` clocks. The block is armed by `enable`. While armed it waits for a start bit and watches the clock-present flag, the card reset line and a cycle limit for the wait. When a start edge is accepted, it samples the character in the middle of each bit and reports the byte together with a 3-bit status code.

The line is never driven during reception, so the pull-up holds it high. When the parity check fails and the card clock is still present, the block pulls the line low for a little over one ETU. The pull starts shortly before 10.5 ETU from the start edge and asks the sender to repeat the character. Two conventions are supported. In direct convention the first data bit is the LSB. In inverse convention the line levels and the bit order are both reversed. Grouping characters into frames is done elsewhere.

The line, reset and clock-present inputs each pass through a two-flop synchronizer before the block uses them.

Top module: `sc_char_rx`

## Requirements
- R1: After reset, `done`, `io_drive_low`, `status` and `data` are all 0.
- R2: While the block waits for a start bit, it checks the following conditions every cycle, in this order of priority, and ends the reception on the first one that holds:
  - The clock-present input is low: status 4.
  - The card reset line is low: status 3.
  - A falling edge appears on the line: the character is received.
  - The block has waited `wait_limit` cycles with no start edge: status 2.
  
  A `wait_limit` of 0 disables the timeout. For status 2, 3 and 4, `data` is 0.
- R3: If the line is high one half ETU after the falling edge, the start is false. The block reports status 1 with `data` 0 and does not drive the line.
- R4: In direct convention (`inverse`=0), each of the 8 data bits is sampled one ETU after the previous sample. A high sample gives a 1, and the first bit received is bit 0 of `data`.
- R5: In inverse convention (`inverse`=1), a low sample gives a 1, and the first bit received is bit 7 of `data`.
- R6: The parity bit is sampled one ETU after the last data bit. The check is even parity over the 8 logical data bits plus the logical parity bit. A pass gives status 0 with the received byte.
- R7: On a parity failure with the clock present, `io_drive_low` is high for exactly `ETU_CYCLES + ETU_CYCLES/8` cycles. The pulse starts between 10 and 10.5 ETU after the start edge. `done` follows after the line has been released, with status 1 and the received byte.
- R8: On a parity failure while the clock-present input is low, the line is not driven. The block reports status 1 with the received byte.
- R9: `done` is a single-cycle pulse. `status` and `data` change only in the cycle in which `done` is high.
- R10: The line is never pulled low while the block waits for a start bit or receives a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; one ETU is `ETU_CYCLES` cycles |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Arms reception of one character when the block is idle |
| inverse | input | 1 | 1 selects inverse convention, 0 selects direct |
| io_line | input | 1 | Level of the card I/O line |
| card_rst_n | input | 1 | Level of the card reset line; low means reset asserted |
| clk_ok | input | 1 | High while the card clock is present |
| wait_limit | input | WAIT_W | Maximum number of cycles to wait for a start bit; 0 waits forever |
| io_drive_low | output | 1 | When high, the I/O line is pulled low (error signal) |
| done | output | 1 | One-cycle pulse when a reception ends |
| status | output | 3 | 0 ok, 1 parity error or false start, 2 timeout, 3 reset low, 4 no clock |
| data | output | 8 | Received byte |

## Verification
While the block waits for a start bit, the clock-present input and the card reset line can both drop in the same cycle. The bench lowers both together before it arms the block and expects status 4, because the missing clock has priority over the reset line.

A second collision happens at the end of a character: the parity failure and the loss of the clock meet at the same decision point. The bench drops `clk_ok` in the middle of a character whose parity is wrong. The result is judged by the absence of any pull on the line together with status 1 and the received byte.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

    typedef enum logic [2:0] {
        RX_OK      = 3'd0,
        RX_PARERR  = 3'd1,
        RX_TIMEOUT = 3'd2,
        RX_RSTLOW  = 3'd3,
        RX_NOCLK   = 3'd4
    } rx_status_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT,
        S_HALF,
        S_DATA,
        S_PAR,
        S_TAIL,
        S_EPRE,
        S_ELOW,
        S_EREL
    } rx_state_e;

    // x is the XOR of all nine sampled line levels (data plus parity).
    // Direct convention passes when x is 0. Inverse convention passes
    // when x is 1, because nine inverted bits flip the XOR.
    function automatic logic parity_pass(input logic x, input logic inv);
        return x == inv;
    endfunction

endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Every input idles high, so each stage resets to 1.
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[i] <= 1'b1;
                q[i]    <= 1'b1;
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/sc_rx_timer.sv
module sc_rx_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    // Fires after `limit` cycles when the counter is cleared on every expiry.
    assign expire = (cnt == limit - 1'b1);
endmodule

// File: rtl/sc_rx_shifter.sv
module sc_rx_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       shift,
    input  logic       inverse,
    input  logic       line,
    output logic [7:0] byte_q,
    output logic       line_xor
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            byte_q   <= '0;
            line_xor <= 1'b0;
        end else if (shift) begin
            line_xor <= line_xor ^ line;
            if (inverse) byte_q <= {byte_q[6:0], ~line};  // first bit ends at MSB
            else         byte_q <= {line, byte_q[7:1]};   // first bit ends at LSB
        end
    end
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
    import sc_rx_pkg::*;
#(
    parameter int ETU_CYCLES = 372,
    parameter int WAIT_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              inverse,
    input  logic              io_line,
    input  logic              card_rst_n,
    input  logic              clk_ok,
    input  logic [WAIT_W-1:0] wait_limit,
    output logic              io_drive_low,
    output logic              done,
    output logic [2:0]        status,
    output logic [7:0]        data
);
    localparam int HALF_CYC  = ETU_CYCLES / 2;
    localparam int GUARD_CYC = ETU_CYCLES / 8;
    localparam int PRE_CYC   = HALF_CYC - GUARD_CYC;
    localparam int LOW_CYC   = ETU_CYCLES + GUARD_CYC;
    localparam int CW        = $clog2(LOW_CYC + 1) + 1;

    // ---------------- input synchronizers ----------------
    logic [2:0] sync_q;
    logic       io_s, rst_s, clk_ok_s;

    sc_rx_sync #(.W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({clk_ok, card_rst_n, io_line}),
        .q   (sync_q)
    );
    assign io_s     = sync_q[0];
    assign rst_s    = sync_q[1];
    assign clk_ok_s = sync_q[2];

    // ---------------- state and control ----------------
    rx_state_e          state, nxt;
    logic [2:0]         bit_idx;
    logic [WAIT_W-1:0]  wait_cnt;
    logic               io_prev, par_line;
    logic               fall, expire, tclr;
    logic               fin, fin_keep, clr_sh, shift, take_par;
    rx_status_e         fin_st;
    logic [CW-1:0]      tlim;
    logic [7:0]         byte_q;
    logic               line_xor;

    assign fall = io_prev & ~io_s;

    always_comb begin
        case (state)
            S_HALF, S_TAIL: tlim = CW'(HALF_CYC);
            S_EPRE, S_EREL: tlim = CW'(PRE_CYC);
            S_ELOW:         tlim = CW'(LOW_CYC);
            default:        tlim = CW'(ETU_CYCLES);
        endcase
    end

    sc_rx_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr    (tclr),
        .limit  (tlim),
        .expire (expire)
    );

    sc_rx_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_sh),
        .shift    (shift),
        .inverse  (inverse),
        .line     (io_s),
        .byte_q   (byte_q),
        .line_xor (line_xor)
    );

    always_comb begin
        nxt      = state;
        fin      = 1'b0;
        fin_keep = 1'b0;
        fin_st   = RX_OK;
        clr_sh   = 1'b0;
        shift    = 1'b0;
        take_par = 1'b0;
        case (state)
            S_IDLE: if (enable) nxt = S_WAIT;
            S_WAIT: begin
                if (!clk_ok_s) begin
                    fin = 1'b1; fin_st = RX_NOCLK;
                end else if (!rst_s) begin
                    fin = 1'b1; fin_st = RX_RSTLOW;
                end else if (fall) begin
                    nxt = S_HALF; clr_sh = 1'b1;
                end else if (wait_limit != '0 && wait_cnt == wait_limit - 1'b1) begin
                    fin = 1'b1; fin_st = RX_TIMEOUT;
                end
            end
            S_HALF: if (expire) begin
                if (io_s) begin
                    fin = 1'b1; fin_st = RX_PARERR;    // false start
                end else begin
                    nxt = S_DATA;
                end
            end
            S_DATA: if (expire) begin
                shift = 1'b1;
                if (bit_idx == 3'd7) nxt = S_PAR;
            end
            S_PAR: if (expire) begin
                take_par = 1'b1; nxt = S_TAIL;
            end
            S_TAIL: if (expire) begin
                if (parity_pass(line_xor ^ par_line, inverse)) begin
                    fin = 1'b1; fin_keep = 1'b1; fin_st = RX_OK;
                end else if (clk_ok_s) begin
                    nxt = S_EPRE;
                end else begin
                    fin = 1'b1; fin_keep = 1'b1; fin_st = RX_PARERR;
                end
            end
            S_EPRE: if (expire) nxt = S_ELOW;
            S_ELOW: if (expire) nxt = S_EREL;
            S_EREL: if (expire) begin
                fin = 1'b1; fin_keep = 1'b1; fin_st = RX_PARERR;
            end
            default: nxt = S_IDLE;
        endcase
        if (fin) nxt = S_IDLE;
        tclr = (nxt != state) || expire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            bit_idx      <= '0;
            wait_cnt     <= '0;
            io_prev      <= 1'b1;
            par_line     <= 1'b0;
            done         <= 1'b0;
            status       <= 3'd0;
            data         <= '0;
            io_drive_low <= 1'b0;
        end else begin
            state        <= nxt;
            io_prev      <= io_s;
            done         <= fin;
            io_drive_low <= (nxt == S_ELOW);
            wait_cnt     <= (state == S_WAIT) ? wait_cnt + 1'b1 : '0;
            if (clr_sh)        bit_idx <= '0;
            else if (shift)    bit_idx <= bit_idx + 1'b1;
            if (take_par)      par_line <= io_s;
            if (fin) begin
                status <= fin_st;
                data   <= fin_keep ? byte_q : 8'h00;
            end
        end
    end
endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk #(
    parameter int LOW_CYC = 46
) (
    input logic       clk,
    input logic       rst,
    input logic       done,
    input logic [2:0] status,
    input logic [7:0] data,
    input logic       io_drive_low
);
    logic [15:0] low_len;

    always_ff @(posedge clk) begin
        if (rst)               low_len <= '0;
        else if (io_drive_low) low_len <= low_len + 1'b1;
        else                   low_len <= '0;
    end

    // R2 status codes stay inside the defined set
    a_r2_status_code: assert property (@(posedge clk) disable iff (rst)
        done |-> status <= 3'd4);

    // R9 done lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9 data changes only together with done
    a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(data));

    // R7 error pulse has the stated width
    a_r7_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $fell(io_drive_low) |-> low_len == 16'(LOW_CYC));

    // R7 completion is reported only after a release wait
    a_r7_release_first: assert property (@(posedge clk) disable iff (rst)
        $fell(io_drive_low) |-> !done);
endmodule

bind sc_char_rx sc_char_rx_chk #(.LOW_CYC(LOW_CYC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .done         (done),
    .status       (status),
    .data         (data),
    .io_drive_low (io_drive_low)
);

// File: tb/sc_char_rx_test.sv
module sc_char_rx_test;
    localparam int CLK_PERIOD = 10;
    localparam int ETU        = 32;
    localparam int LOW_W      = ETU + ETU / 8;
    localparam int WAIT_W     = 16;

    typedef struct {
        logic [2:0] st;
        logic [7:0] dat;
        bit         pulse;
        string      req;
    } exp_t;

    logic clk = 1'b0, rst = 1'b1, enable = 1'b0, inverse = 1'b0;
    logic drv = 1'b1, card_rst_n = 1'b1, clk_ok = 1'b1;
    logic [WAIT_W-1:0] wait_limit = '0;
    logic io_drive_low, done;
    logic [2:0] status;
    logic [7:0] data;
    wire  io_line = drv & ~io_drive_low;

    int checks = 0, failures = 0, cyc = 0, done_cnt = 0, edge_cyc = 0;
    int p_start = -1, p_len = 0;
    bit p_prev = 0;
    exp_t q[$];

    sc_char_rx #(.ETU_CYCLES(ETU), .WAIT_W(WAIT_W)) uut (
        .clk(clk), .rst(rst), .enable(enable), .inverse(inverse),
        .io_line(io_line), .card_rst_n(card_rst_n), .clk_ok(clk_ok),
        .wait_limit(wait_limit), .io_drive_low(io_drive_low),
        .done(done), .status(status), .data(data));

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard pop and pulse tracking
    always @(negedge clk) begin
        if (!rst) begin
            if (io_drive_low) begin
                if (!p_prev) p_start = cyc - edge_cyc;
                p_len++;
            end
            p_prev = io_drive_low;
            if (done) begin
                exp_t e;
                done_cnt++;
                if (q.size() == 0) begin
                    check(0, "R9", "unexpected done", 1, 0);
                end else begin
                    e = q.pop_front();
                    check(status == e.st, e.req, "status", status, e.st);
                    check(data == e.dat, e.req, "data", data, e.dat);
                    check((p_len != 0) == e.pulse, e.req, "pulse seen", p_len != 0, e.pulse);
                    if (e.pulse) begin
                        check(p_len == LOW_W, "R7", "pulse width", p_len, LOW_W);
                        check(p_start >= 10 * ETU && p_start <= 10 * ETU + ETU / 2,
                              "R7", "pulse start", p_start, 10 * ETU + ETU / 2);
                    end
                end
                p_len = 0; p_start = -1;
            end
        end
    end

    function automatic logic [9:0] frame(input logic [7:0] b, input bit inv, input bit bad);
        logic [9:0] f;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) f[1 + i] = inv ? ~b[7 - i] : b[i];
        f[9] = (inv ? ~(^b) : (^b)) ^ bad;
        return f;
    endfunction

    task automatic arm();
        @(negedge clk) enable = 1'b1;
        @(negedge clk) enable = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_done(input int n);
        int guard = 0;
        while (done_cnt < n && guard < 2000) begin
            @(negedge clk); guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input bit inv, input bit bad,
                        input bit drop_clk, input exp_t e);
        logic [9:0] f = frame(b, inv, bad);
        int n = done_cnt + 1;
        inverse = inv;
        q.push_back(e);
        arm();
        edge_cyc = cyc;
        for (int k = 0; k < 10; k++) begin
            drv = f[k];
            if (drop_clk && k == 5) clk_ok = 1'b0;
            repeat (ETU) @(negedge clk);
        end
        drv = 1'b1;
        wait_done(n);
        clk_ok = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic abort_case(input logic ck, input logic rn, input int lim, input exp_t e);
        int n = done_cnt + 1;
        clk_ok = ck; card_rst_n = rn; wait_limit = WAIT_W'(lim);
        repeat (4) @(negedge clk);
        q.push_back(e);
        arm();
        wait_done(n);
        clk_ok = 1'b1; card_rst_n = 1'b1; wait_limit = '0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        check(0, "WATCHDOG", "run did not finish", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(done == 0 && io_drive_low == 0, "R1", "done/drive", {done, io_drive_low}, 0);
        check(status == 0 && data == 0, "R1", "status/data", {status, data}, 0);

        // R4 R6 direct convention, several patterns
        send(8'h5A, 0, 0, 0, '{3'd0, 8'h5A, 0, "R4"});
        send(8'hFF, 0, 0, 0, '{3'd0, 8'hFF, 0, "R6"});
        send(8'h00, 0, 0, 0, '{3'd0, 8'h00, 0, "R6"});
        send(8'h81, 0, 0, 0, '{3'd0, 8'h81, 0, "R10"});
        // R5 inverse convention
        send(8'h3B, 1, 0, 0, '{3'd0, 8'h3B, 0, "R5"});
        send(8'hC4, 1, 0, 0, '{3'd0, 8'hC4, 0, "R5"});
        // R7 parity error signalled on the line
        send(8'h5A, 0, 1, 0, '{3'd1, 8'h5A, 1, "R7"});
        send(8'h3B, 1, 1, 0, '{3'd1, 8'h3B, 1, "R7"});
        // R8 parity error with clock lost mid-character
        send(8'hA5, 0, 1, 1, '{3'd1, 8'hA5, 0, "R8"});

        // R3 false start: short glitch
        n = done_cnt + 1;
        inverse = 1'b0;
        q.push_back('{3'd1, 8'h00, 0, "R3"});
        arm();
        drv = 1'b0; repeat (4) @(negedge clk); drv = 1'b1;
        wait_done(n);
        repeat (4) @(negedge clk);

        // R2 aborts while waiting
        abort_case(1'b1, 1'b1, 50, '{3'd2, 8'h00, 0, "R2"});
        abort_case(1'b1, 1'b0, 0,  '{3'd3, 8'h00, 0, "R2"});
        abort_case(1'b0, 1'b1, 0,  '{3'd4, 8'h00, 0, "R2"});
        abort_case(1'b0, 1'b0, 0,  '{3'd4, 8'h00, 0, "R2"});

        // R2 limit 0 waits forever, then still receives
        n = done_cnt;
        wait_limit = '0;
        arm();
        repeat (2000) @(negedge clk);
        check(done_cnt == n, "R2", "done while waiting forever", done_cnt, n);
        q.push_back('{3'd0, 8'h96, 0, "R2"});
        begin
            logic [9:0] f = frame(8'h96, 0, 0);
            edge_cyc = cyc;
            for (int k = 0; k < 10; k++) begin
                drv = f[k];
                repeat (ETU) @(negedge clk);
            end
            drv = 1'b1;
        end
        wait_done(n + 1);

        check(q.size() == 0, "R9", "pending expectations", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule